// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch Folding

This block sits between an instruction fetch unit and a decode unit. Each cycle the fetch side may push one instruction into the queue, and the decode side may take one out. When decode stalls, for example behind an execute step that takes several cycles, fetch keeps filling the queue until no space is left. Later, when fetch stalls on a slow memory access, the stored entries keep decode busy.

Every fetched word carries a flag that marks it as an unconditional branch, together with the branch target address. Decode never receives a branch. When a branch is the oldest entry, or sits directly behind the oldest entry, the queue sends a one-cycle redirect with the target to the fetch unit. In the same cycle it drops the branch and every entry younger than it, because those were fetched along the sequential path. When a non-branch instruction is ahead of the branch, decode still gets a valid instruction in the folding cycle, so the branch costs no decode slot. A branch that reaches an empty queue costs exactly one empty decode cycle.

Top module: `ipq_top`

## Requirements
- R1: After synchronous reset the queue is empty: `dc_valid` and `redir_valid` are 0 and `fe_ready` is 1.
- R2: Non-branch instructions reach decode in the order they were accepted, one per cycle when `dc_ready` is high. A word accepted in cycle t is visible on `dc_instr` no earlier than cycle t+1.
- R3: While decode is stalled, accepted writes accumulate up to DEPTH entries (default 4). When the queue holds DEPTH entries and nothing leaves in that cycle, `fe_ready` is 0 and a write is refused.
- R4: With the queue full, a write and a decode read in the same cycle are both accepted and the occupancy stays at DEPTH.
- R5: A word written with `fe_is_br`=1 is never presented to decode. When it is the oldest entry, `redir_valid` is 1 for that cycle with `redir_target` equal to its target, `dc_valid` is 0 in that cycle, and every entry behind it is discarded.
- R6: When the oldest entry is a non-branch and the next one is a branch, the redirect is issued in that cycle. The oldest entry stays on `dc_instr` with `dc_valid`=1, or is consumed if `dc_ready` is 1, and all entries after the branch are discarded.
- R7: A write accepted in a cycle with `redir_valid`=1 is discarded, since it belongs to the sequential path.
- R8: While `dc_valid` is 1 and `dc_ready` is 0, `dc_instr` holds its value into the next cycle.
- R9: When the queue holds entries and `fe_valid` is low, decode keeps receiving one instruction per cycle until the stored non-branch entries are used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch side offers a word |
| fe_instr | input | 32 | Fetched instruction word |
| fe_is_br | input | 1 | Word is an unconditional branch |
| fe_target | input | 16 | Branch target address (used when `fe_is_br`=1) |
| fe_ready | output | 1 | Queue accepts a word this cycle |
| dc_valid | output | 1 | An instruction is offered to decode |
| dc_instr | output | 32 | Oldest non-branch instruction |
| dc_ready | input | 1 | Decode takes the offered instruction |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_target | output | 16 | Address at which fetch resumes |

## Verification
The hardest case to reach is a branch folded from the second slot while decode is stalled and wrong-path words are still arriving. In that case the redirect, the retained oldest entry and the dropped same-cycle write all meet in one cycle. The stimulus holds `dc_ready` low, pushes one plain word, then a branch, then more plain words, and releases decode only afterwards. A long pseudo-random run mixes branches, stalls and fetch gaps. A cycle-level reference model in the bench predicts every output during that run.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
    localparam int unsigned IPQ_IW = 32;
    localparam int unsigned IPQ_AW = 16;

    typedef struct packed {
        logic              is_br;
        logic [IPQ_AW-1:0] target;
        logic [IPQ_IW-1:0] instr;
    } ipq_entry_t;

    typedef enum logic [1:0] {
        FOLD_NONE = 2'd0,
        FOLD_HEAD = 2'd1,
        FOLD_NEXT = 2'd2
    } fold_e;

    function automatic int unsigned ipq_wrap(input int unsigned v, input int unsigned depth);
        return (v >= depth) ? v - depth : v;
    endfunction
endpackage

// File: rtl/ipq_store.sv
module ipq_store
    import ipq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  ipq_entry_t        wr_data,
    input  logic [PW-1:0]     rd0_idx,
    input  logic [PW-1:0]     rd1_idx,
    output ipq_entry_t        rd0,
    output logic              rd1_br,
    output logic [IPQ_AW-1:0] rd1_tgt
);
    ipq_entry_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PW'(g)))
                slot[g] <= wr_data;
        end
    end

    always_comb begin
        rd0     = slot[rd0_idx];
        rd1_br  = slot[rd1_idx].is_br;
        rd1_tgt = slot[rd1_idx].target;
    end
endmodule

// File: rtl/ipq_ctrl.sv
module ipq_ctrl
    import ipq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fe_valid,
    input  logic          dc_ready,
    input  logic          head_br,
    input  logic          next_br,
    output logic [PW-1:0] head_idx,
    output logic [PW-1:0] next_idx,
    output logic [PW-1:0] tail_idx,
    output logic          wr_en,
    output logic          dc_valid,
    output logic          fe_ready,
    output fold_e         fold
);
    logic [PW-1:0] head_q;
    logic [CW-1:0] count_q;
    logic          have0, have1, pop;

    always_comb begin
        have0    = (count_q != '0);
        have1    = (count_q > CW'(1));
        head_idx = head_q;
        next_idx = PW'(ipq_wrap(int'(head_q) + 1, DEPTH));
        tail_idx = PW'(ipq_wrap(int'(head_q) + int'(count_q), DEPTH));
        if (have0 && head_br)
            fold = FOLD_HEAD;
        else if (have1 && next_br)
            fold = FOLD_NEXT;
        else
            fold = FOLD_NONE;
        dc_valid = have0 && !head_br;
        pop      = dc_valid && dc_ready;
        fe_ready = (count_q != CW'(DEPTH)) || pop || (fold != FOLD_NONE);
        wr_en    = fe_valid && fe_ready && (fold == FOLD_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            case (fold)
                FOLD_HEAD: begin
                    head_q  <= next_idx;
                    count_q <= '0;
                end
                FOLD_NEXT: begin
                    head_q  <= pop ? next_idx : head_q;
                    count_q <= pop ? CW'(0) : CW'(1);
                end
                default: begin
                    head_q  <= pop ? next_idx : head_q;
                    count_q <= count_q + CW'(wr_en) - CW'(pop);
                end
            endcase
        end
    end

    // R3: occupancy never exceeds the storage size
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

    // R4: full queue with a write and a read stays full
    a_r4_full_swap: assert property (@(posedge clk) disable iff (rst)
        (count_q == CW'(DEPTH) && pop && fe_valid && fold == FOLD_NONE) |=> count_q == CW'(DEPTH));

    // R5: the redirect lasts one cycle only
    a_r5_redir_pulse: assert property (@(posedge clk) disable iff (rst)
        (fold != FOLD_NONE) |=> (fold == FOLD_NONE));

    // R5: folding a head branch empties the queue
    a_r5_head_flush: assert property (@(posedge clk) disable iff (rst)
        (fold == FOLD_HEAD) |=> (count_q == '0));

    // R2: without a redirect, occupancy moves by at most one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (fold == FOLD_NONE) |=> (count_q == $past(count_q)) ||
                                (count_q == $past(count_q) + CW'(1)) ||
                                (count_q + CW'(1) == $past(count_q)));
endmodule

// File: rtl/ipq_top.sv
module ipq_top
    import ipq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_valid,
    input  logic [IPQ_IW-1:0] fe_instr,
    input  logic              fe_is_br,
    input  logic [IPQ_AW-1:0] fe_target,
    output logic              fe_ready,
    output logic              dc_valid,
    output logic [IPQ_IW-1:0] dc_instr,
    input  logic              dc_ready,
    output logic              redir_valid,
    output logic [IPQ_AW-1:0] redir_target
);
    logic [PW-1:0]     head_idx, next_idx, tail_idx;
    logic              wr_en, rd1_br;
    logic [IPQ_AW-1:0] rd1_tgt;
    ipq_entry_t        wr_data, rd0;
    fold_e             fold;

    assign wr_data = '{is_br: fe_is_br, target: fe_target, instr: fe_instr};

    ipq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (tail_idx),
        .wr_data (wr_data),
        .rd0_idx (head_idx),
        .rd1_idx (next_idx),
        .rd0     (rd0),
        .rd1_br  (rd1_br),
        .rd1_tgt (rd1_tgt)
    );

    ipq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fe_valid (fe_valid),
        .dc_ready (dc_ready),
        .head_br  (rd0.is_br),
        .next_br  (rd1_br),
        .head_idx (head_idx),
        .next_idx (next_idx),
        .tail_idx (tail_idx),
        .wr_en    (wr_en),
        .dc_valid (dc_valid),
        .fe_ready (fe_ready),
        .fold     (fold)
    );

    always_comb begin
        dc_instr     = rd0.instr;
        redir_valid  = (fold != FOLD_NONE);
        redir_target = (fold == FOLD_HEAD) ? rd0.target : rd1_tgt;
    end

    // R8: a stalled instruction is held for decode
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (dc_valid && !dc_ready) |=> (dc_valid && $stable(dc_instr)));
endmodule

// File: tb/tb_ipq_top.sv
`timescale 1ns/1ps
module tb_ipq_top;
    localparam int unsigned DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fe_valid = 1'b0, fe_is_br = 1'b0, dc_ready = 1'b0;
    logic [31:0] fe_instr = '0;
    logic [15:0] fe_target = '0;
    logic        fe_ready, dc_valid, redir_valid;
    logic [31:0] dc_instr;
    logic [15:0] redir_target;

    int n_chk = 0;
    int n_bad = 0;

    // reference queue contents
    logic [31:0] m_instr [$];
    logic        m_br    [$];
    logic [15:0] m_tgt   [$];

    always #2.5 clk = ~clk;

    ipq_top #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .fe_valid(fe_valid), .fe_instr(fe_instr),
        .fe_is_br(fe_is_br), .fe_target(fe_target), .fe_ready(fe_ready),
        .dc_valid(dc_valid), .dc_instr(dc_instr), .dc_ready(dc_ready),
        .redir_valid(redir_valid), .redir_target(redir_target)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check, then advance the model
    task automatic cyc(input logic fv, input logic [31:0] fi, input logic fb,
                       input logic [15:0] ft, input logic dr, input string tag);
        logic v0, v1, b0, b1, e_dcv, e_red, e_rdy, popm, wrm, f0, f1;
        logic [15:0] e_tgt;
        @(negedge clk);
        fe_valid = fv; fe_instr = fi; fe_is_br = fb; fe_target = ft; dc_ready = dr;
        #1;
        v0 = (m_instr.size() >= 1);
        v1 = (m_instr.size() >= 2);
        b0 = v0 && m_br[0];
        b1 = v1 && m_br[1];
        f0 = b0;
        f1 = !f0 && b1;
        e_dcv = v0 && !b0;
        e_red = f0 || f1;
        e_tgt = f0 ? m_tgt[0] : (f1 ? m_tgt[1] : 16'h0);
        popm  = e_dcv && dr;
        e_rdy = (m_instr.size() < DEPTH) || popm || e_red;
        wrm   = fv && e_rdy && !e_red;
        chk(tag, "dc_valid", 32'(dc_valid), 32'(e_dcv));
        if (e_dcv) chk(tag, "dc_instr", dc_instr, m_instr[0]);
        chk(tag, "redir_valid", 32'(redir_valid), 32'(e_red));
        if (e_red) chk(tag, "redir_target", 32'(redir_target), 32'(e_tgt));
        chk(tag, "fe_ready", 32'(fe_ready), 32'(e_rdy));
        if (f0) begin
            m_instr.delete(); m_br.delete(); m_tgt.delete();
        end else if (f1) begin
            if (popm) begin
                m_instr.delete(); m_br.delete(); m_tgt.delete();
            end else begin
                while (m_instr.size() > 1) begin
                    void'(m_instr.pop_back()); void'(m_br.pop_back()); void'(m_tgt.pop_back());
                end
            end
        end else begin
            if (popm) begin
                void'(m_instr.pop_front()); void'(m_br.pop_front()); void'(m_tgt.pop_front());
            end
            if (wrm) begin
                m_instr.push_back(fi); m_br.push_back(fb); m_tgt.push_back(ft);
            end
        end
    endtask

    task automatic wr(input logic [31:0] i, input logic dr, input string tag);
        cyc(1'b1, i, 1'b0, 16'h0, dr, tag);
    endtask
    task automatic br(input logic [15:0] t, input logic dr, input string tag);
        cyc(1'b1, 32'hB0B0_0000 | 32'(t), 1'b1, t, dr, tag);
    endtask
    task automatic idle(input logic dr, input string tag);
        cyc(1'b0, 32'h0, 1'b0, 16'h0, dr, tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle(1'b0, "R1");
        chk("R1", "fe_ready after reset", 32'(fe_ready), 32'd1);

        // R2: streaming with decode always ready
        for (int i = 0; i < 6; i++) wr(32'h1000 + 32'(i), 1'b1, "R2");
        idle(1'b1, "R2");
        idle(1'b1, "R2");

        // R3: fill while decode stalled, fifth write refused
        for (int i = 0; i < 5; i++) wr(32'h2000 + 32'(i), 1'b0, "R3");
        chk("R3", "fe_ready when full", 32'(fe_ready), 32'd0);
        // R4: write and read together when full
        wr(32'h2100, 1'b1, "R4");
        idle(1'b0, "R4");
        chk("R4", "still full", 32'(fe_ready), 32'd0);
        // R8: held while stalled, then drained
        idle(1'b0, "R8");
        for (int i = 0; i < 5; i++) idle(1'b1, "R2");

        // R5 and R7: branch into an empty queue, write during redirect dropped
        br(16'h0040, 1'b1, "R5");
        wr(32'h0BAD, 1'b1, "R7");
        wr(32'h0040, 1'b1, "R5");
        idle(1'b1, "R5");

        // R6: branch behind a stalled head, wrong-path words following
        wr(32'h3000, 1'b0, "R6");
        idle(1'b0, "R6");
        br(16'h0080, 1'b0, "R6");
        wr(32'h3BAD, 1'b0, "R7");
        wr(32'h0080, 1'b0, "R6");
        idle(1'b0, "R8");
        idle(1'b1, "R6");
        idle(1'b1, "R6");

        // R6: branch reaches second slot only after decode resumes
        wr(32'h4000, 1'b0, "R6");
        wr(32'h4001, 1'b0, "R6");
        br(16'h00C0, 1'b0, "R6");
        wr(32'h4BAD, 1'b0, "R6");
        idle(1'b1, "R6");
        idle(1'b1, "R6");
        idle(1'b1, "R6");

        // R9: fetch miss hidden by stored entries
        for (int i = 0; i < 3; i++) wr(32'h5000 + 32'(i), 1'b0, "R9");
        for (int i = 0; i < 4; i++) idle(1'b1, "R9");

        // R2: pseudo-random mix of branches, stalls and gaps
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[0], lfsr, (lfsr[3:1] == 3'd0), lfsr[31:16], lfsr[4] | lfsr[5], "R2");
        end
        for (int i = 0; i < 8; i++) idle(1'b1, "R2");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule